// File: doc/BRIEF.md
# Masked Privileged Register File

This block is a bank of 64-bit control registers for a processor core, read and written through an index with separate read and write strobes. Every register has its own write rule. Plain registers store the whole word. Masked registers keep only certain bits. Exception-record registers collect event bits from the core and are cleared by any write. Identity registers can only be read, and command registers can only be written. One cycle-count register returns its stored upper half together with the low 32 bits of a free-running counter.

Reads are combinational, so data and the error flag appear in the cycle the strobe is applied. A write takes effect at the next rising clock edge. An illegal access raises `err` for that cycle only. A `squash` input suppresses writes that belong to misspeculated instructions.

Index map:
- 0..SCRATCH_N-1: scratch registers.
- 16: machine control.
- 17: exception address.
- 18 and 19: AST request and AST enable.
- 20: interrupt priority level.
- 21: current mode.
- 22: alternate mode.
- 23: software interrupt request.
- 24: control/status.
- 25 and 26: instruction-side and memory-side page table bases.
- 27 and 28: ITB ASN and DTB ASN.
- 29 and 30: exception summary and exception mask.
- 31: cycle count.
- 32: identity.
- 33: memory status.
- 34: interrupt clear.
- 35: cache flush.

Every other index is unknown.

Top module: `priv_reg_bank`

## Requirements
- R1: After reset every register reads as zero, with three exceptions. Machine control (16) reads 0x6. Scratch slot CPUID_SLOT (default 7) and identity (32) read the `cpu_id` input, zero-extended.
- R2: Scratch registers 0..SCRATCH_N-1 (default 8) and machine control (16) store the full 64-bit written word.
- R3: Writes are masked per register. Exception address (17) stores data with bit 1 forced to zero. Registers 18 and 19 keep mask 0xf. Register 20 keeps 0x1f. Registers 21 and 22 keep 0x18. Register 23 keeps 0x7fff0. Register 24 keeps 0xffffff0300. Registers 25 and 26 keep 0xffffffffc0000000. Register 27 keeps 0x7f0. Register 28 keeps 0xfe00000000000000. Registers 34 and 35 keep all bits.
- R4: Each clock, the exception summary (29) and exception mask (30) registers OR in the bits of `exc_evt`. Any unsquashed write to either register sets it to zero, whatever the data. On that edge the write takes precedence over `exc_evt`.
- R5: A read of cycle count (31) returns bits [63:32] of the last value written to it, joined with the low 32 bits of the cycle counter in bits [31:0].
- R6: The cycle counter is zero during reset. It increases by one at every rising edge after reset is released.
- R7: A write to a read-only register (32, 33) raises `err` and leaves the register unchanged.
- R8: A read of a write-only register (22, 34, 35) or of an unknown index raises `err`. Whenever `err` is high, `rd_data` is zero. When `rd_en` is low, `rd_data` is also zero.
- R9: While `squash` is high, a write changes no register and raises no error.
- R10: `err` is high only in a cycle where `rd_en` or `wr_en` is high. A read in the same cycle as a write to the same register returns the old value, and the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_id | input | CPUID_W | Processor identifier used for reset values |
| squash | input | 1 | Suppresses writes (misspeculated access) |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| idx | input | IDX_W | Register index |
| wdata | input | 64 | Write data |
| exc_evt | input | 64 | Exception event bits ORed into registers 29 and 30 |
| rd_data | output | 64 | Read data, combinational |
| err | output | 1 | Illegal-access pulse, combinational |

## Verification
A wrong mask or write rule in any register shows up at `rd_data` on the first read of that index after the faulty write, one cycle later at the earliest. A broken kind decode shows up as a wrong `err` in the same cycle as the strobe, on any access to the affected index. A stalled or misreset counter appears in the low half of the cycle-count read at once, because every read is compared with a cycle-exact model. Squash leaks and lost exception bits surface on the next read of the touched register.

// File: rtl/prf_pkg.sv
package prf_pkg;
   typedef enum logic [2:0] {K_NONE, K_RW, K_RO, K_WO, K_CLR, K_CYC} reg_kind_e;

   localparam int unsigned SYS_BASE  = 16;
   localparam int unsigned NUM_SLOT  = 36;
   localparam int unsigned IX_MCTL   = 16;
   localparam int unsigned IX_EXCA   = 17;
   localparam int unsigned IX_ASTQ   = 18;
   localparam int unsigned IX_ASTE   = 19;
   localparam int unsigned IX_IPL    = 20;
   localparam int unsigned IX_CMODE  = 21;
   localparam int unsigned IX_AMODE  = 22;
   localparam int unsigned IX_SWIRQ  = 23;
   localparam int unsigned IX_CSR    = 24;
   localparam int unsigned IX_IPTB   = 25;
   localparam int unsigned IX_MPTB   = 26;
   localparam int unsigned IX_IASN   = 27;
   localparam int unsigned IX_DASN   = 28;
   localparam int unsigned IX_XSUM   = 29;
   localparam int unsigned IX_XMSK   = 30;
   localparam int unsigned IX_CYC    = 31;
   localparam int unsigned IX_ID     = 32;
   localparam int unsigned IX_MSTAT  = 33;
   localparam int unsigned IX_ICLR   = 34;
   localparam int unsigned IX_FLUSH  = 35;

   function automatic reg_kind_e kind_of(int unsigned ix, int unsigned nscr);
      if (ix < nscr) return K_RW;
      case (ix)
         IX_MCTL, IX_EXCA, IX_ASTQ, IX_ASTE, IX_IPL, IX_CMODE,
         IX_SWIRQ, IX_CSR, IX_IPTB, IX_MPTB, IX_IASN, IX_DASN: return K_RW;
         IX_AMODE, IX_ICLR, IX_FLUSH:                          return K_WO;
         IX_XSUM, IX_XMSK:                                     return K_CLR;
         IX_CYC:                                               return K_CYC;
         IX_ID, IX_MSTAT:                                      return K_RO;
         default:                                              return K_NONE;
      endcase
   endfunction

   function automatic logic [63:0] mask_of(int unsigned ix);
      case (ix)
         IX_EXCA:            return ~64'h2;
         IX_ASTQ, IX_ASTE:   return 64'hf;
         IX_IPL:             return 64'h1f;
         IX_CMODE, IX_AMODE: return 64'h18;
         IX_SWIRQ:           return 64'h7fff0;
         IX_CSR:             return 64'hff_ffff_0300;
         IX_IPTB, IX_MPTB:   return 64'hffff_ffff_c000_0000;
         IX_IASN:            return 64'h7f0;
         IX_DASN:            return 64'hfe00_0000_0000_0000;
         default:            return '1;
      endcase
   endfunction
endpackage

// File: rtl/prf_cycle_ctr.sv
module prf_cycle_ctr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   p_ctr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/prf_decode.sv
module prf_decode
   import prf_pkg::*;
#(
   parameter int unsigned IDX_W     = 6,
   parameter int unsigned SCRATCH_N = 8
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             rd_en,
   input  logic             wr_en,
   input  logic             squash,
   output reg_kind_e        kind,
   output logic             rd_go,
   output logic             wr_go,
   output logic             err
);
   logic rd_bad, wr_bad, wr_live;

   always_comb begin
      if (32'(idx) < NUM_SLOT) kind = kind_of(32'(idx), SCRATCH_N);
      else                     kind = K_NONE;
      wr_live = wr_en && !squash;
      rd_bad  = rd_en && (kind == K_NONE || kind == K_WO);
      wr_bad  = wr_live && (kind == K_NONE || kind == K_RO);
      err     = rd_bad || wr_bad;
      rd_go   = rd_en && !err;
      wr_go   = wr_live && !wr_bad;
   end
endmodule

// File: rtl/prf_cell.sv
module prf_cell
   import prf_pkg::*;
#(
   parameter reg_kind_e   KIND = K_RW,
   parameter logic [63:0] MASK = '1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [63:0] rst_val,
   input  logic        we,
   input  logic [63:0] wdata,
   input  logic [63:0] set_bits,
   output logic [63:0] q
);
   logic [63:0] nxt_w;

   generate
      if (KIND == K_CLR) begin : g_clr
         assign nxt_w = '0;
      end else if (KIND == K_RO) begin : g_ro
         assign nxt_w = q;
      end else begin : g_msk
         assign nxt_w = wdata & MASK;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= rst_val;
      else if (we)         q <= nxt_w;
      else if (|set_bits)  q <= q | set_bits;
   end

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!we && set_bits == '0) |=> $stable(q));

   generate
      if (KIND == K_CLR) begin : g_a_clr
         p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> q == '0);
      end else if (KIND != K_RO) begin : g_a_msk
         p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> (q & ~MASK) == '0);
      end
   endgenerate
endmodule

// File: rtl/priv_reg_bank.sv
module priv_reg_bank
   import prf_pkg::*;
#(
   parameter int unsigned IDX_W      = 6,
   parameter int unsigned SCRATCH_N  = 8,
   parameter int unsigned CPUID_SLOT = 7,
   parameter int unsigned CPUID_W    = 8,
   parameter int unsigned CTR_W      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CPUID_W-1:0] cpu_id,
   input  logic               squash,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   idx,
   input  logic [63:0]        wdata,
   input  logic [63:0]        exc_evt,
   output logic [63:0]        rd_data,
   output logic               err
);
   localparam int unsigned N_IDX = 2 ** IDX_W;

   generate
      if (SCRATCH_N == 0 || SCRATCH_N > SYS_BASE) begin : g_bad_scr
         $error("SCRATCH_N must lie in 1..16");
      end
      if (CPUID_SLOT >= SCRATCH_N) begin : g_bad_slot
         $error("CPUID_SLOT must name a scratch register");
      end
      if (N_IDX < NUM_SLOT) begin : g_bad_idx
         $error("IDX_W too small for the register map");
      end
      if (CTR_W < 32 || CPUID_W > 64) begin : g_bad_w
         $error("CTR_W must be at least 32 and CPUID_W at most 64");
      end
   endgenerate

   reg_kind_e         kind;
   logic              rd_go, wr_go;
   logic [CTR_W-1:0]  ctr;
   logic [63:0]       q_arr [N_IDX];
   logic [63:0]       id_ext;

   assign id_ext = 64'(cpu_id);

   prf_decode #(.IDX_W(IDX_W), .SCRATCH_N(SCRATCH_N)) u_dec (
      .idx(idx), .rd_en(rd_en), .wr_en(wr_en), .squash(squash),
      .kind(kind), .rd_go(rd_go), .wr_go(wr_go), .err(err)
   );

   prf_cycle_ctr #(.W(CTR_W)) u_ctr (.clk(clk), .rst_n(rst_n), .count(ctr));

   generate
      for (genvar s = 0; s < N_IDX; s++) begin : g_slot
         localparam reg_kind_e SK = (s < NUM_SLOT) ? kind_of(s, SCRATCH_N) : K_NONE;
         if (SK == K_NONE) begin : g_empty
            assign q_arr[s] = '0;
         end else begin : g_reg
            logic [63:0] rv;
            logic [63:0] sb;
            assign rv = (s == CPUID_SLOT || s == IX_ID) ? id_ext :
                        (s == IX_MCTL) ? 64'h6 : 64'h0;
            assign sb = (SK == K_CLR) ? exc_evt : 64'h0;
            prf_cell #(.KIND(SK), .MASK(mask_of(s))) u_cell (
               .clk(clk), .rst_n(rst_n), .rst_val(rv),
               .we(wr_go && idx == IDX_W'(s)), .wdata(wdata),
               .set_bits(sb), .q(q_arr[s])
            );
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (rd_go) begin
         if (kind == K_CYC) rd_data = {q_arr[IX_CYC][63:32], ctr[31:0]};
         else               rd_data = q_arr[idx];
      end
   end

   p_err_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (rd_en || wr_en));
   p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> rd_data == '0);
   p_squash_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (squash && !rd_en) |-> !err);
   p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> rd_data == '0);
endmodule

// File: tb/sim_priv_reg_bank.sv
module sim_priv_reg_bank;
   localparam int CLK_PERIOD = 10;

   logic        clk = 0, rst_n = 0;
   logic [7:0]  cpu_id = 8'h5a;
   logic        squash = 0, rd_en = 0, wr_en = 0;
   logic [5:0]  idx = '0;
   logic [63:0] wdata = '0, exc_evt = '0;
   logic [63:0] rd_data;
   logic        err;

   int n_chk = 0, n_err = 0;
   logic [63:0] m [64];
   logic [31:0] mc;

   always #(CLK_PERIOD/2) clk = ~clk;

   priv_reg_bank u0 (
      .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .squash(squash),
      .rd_en(rd_en), .wr_en(wr_en), .idx(idx), .wdata(wdata),
      .exc_evt(exc_evt), .rd_data(rd_data), .err(err)
   );

   always @(posedge clk or negedge rst_n)
      if (!rst_n) mc <= 0; else mc <= mc + 1;

   // kind codes: 0 unknown, 1 plain/masked, 2 read-only, 3 write-only, 4 clear, 5 cycle
   function automatic int kind_f(int ix);
      if (ix < 8) return 1;
      if (ix >= 16 && ix <= 28 && ix != 22) return 1;
      if (ix == 22 || ix == 34 || ix == 35) return 3;
      if (ix == 29 || ix == 30) return 4;
      if (ix == 31) return 5;
      if (ix == 32 || ix == 33) return 2;
      return 0;
   endfunction

   function automatic logic [63:0] mask_f(int ix);
      case (ix)
         17: return 64'hffff_ffff_ffff_fffd;
         18, 19: return 64'hf;
         20: return 64'h1f;
         21, 22: return 64'h18;
         23: return 64'h7fff0;
         24: return 64'h00ff_ffff_0300;
         25, 26: return 64'hffff_ffff_c000_0000;
         27: return 64'h7f0;
         28: return 64'hfe00_0000_0000_0000;
         default: return 64'hffff_ffff_ffff_ffff;
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s idx=%0d actual=%h expected=%h", tag, idx, act, exp);
      end
   endtask

   task automatic acc(input bit rd, input bit wr, input bit sq, input int ix,
                      input logic [63:0] wd, input logic [63:0] ev, input string tag);
      int k;
      bit e_err;
      logic [63:0] e_rd;
      @(negedge clk);
      rd_en = rd; wr_en = wr; squash = sq; idx = 6'(ix); wdata = wd; exc_evt = ev;
      #1;
      k = kind_f(ix);
      e_err = (rd && (k == 0 || k == 3)) || (wr && !sq && (k == 0 || k == 2));
      e_rd = '0;
      if (rd && !e_err) e_rd = (k == 5) ? {m[31][63:32], mc} : m[ix];
      check({tag, " err"}, {63'b0, err}, {63'b0, e_err});
      check({tag, " rd_data"}, rd_data, e_rd);
      for (int c = 29; c <= 30; c++) m[c] = m[c] | ev;
      if (wr && !sq && !e_err) begin
         if (k == 4) m[ix] = '0;
         else if (k != 2) m[ix] = wd & mask_f(ix);
      end
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : main
      logic [63:0] a, b;
      for (int i = 0; i < 64; i++) m[i] = '0;
      m[16] = 64'h6; m[7] = 64'h5a; m[32] = 64'h5a;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset values, R8 unknown/write-only reads
      for (int i = 0; i < 64; i++) acc(1, 0, 0, i, 0, 0, "R1/R8");
      // R2 full-width storage
      acc(0, 1, 0, 3, 64'hdead_beef_0123_4567, 0, "R2");
      acc(1, 0, 0, 3, 0, 0, "R2");
      acc(0, 1, 0, 16, 64'hffff_ffff_ffff_ffff, 0, "R2");
      acc(1, 0, 0, 16, 0, 0, "R2");
      // R3 masks, all-ones write then readback
      for (int i = 17; i <= 28; i++) begin
         acc(0, 1, 0, i, '1, 0, "R3");
         acc(1, 0, 0, i, 0, 0, "R3");
      end
      acc(0, 1, 0, 34, '1, 0, "R3");
      acc(0, 1, 0, 35, '1, 0, "R3");
      // R4 event accumulation and clear-on-write
      acc(0, 0, 0, 0, 0, 64'h11, "R4");
      acc(1, 0, 0, 29, 0, 64'h100, "R4");
      acc(1, 0, 0, 30, 0, 0, "R4");
      acc(0, 1, 0, 29, '1, 64'h4, "R4");
      acc(1, 0, 0, 29, 0, 0, "R4");
      acc(1, 0, 0, 30, 0, 0, "R4");
      // R5/R6 cycle count
      acc(0, 1, 0, 31, 64'h1234_5678_ffff_ffff, 0, "R5");
      acc(1, 0, 0, 31, 0, 0, "R5");
      @(negedge clk); rd_en = 1; wr_en = 0; idx = 6'd31; #1; a = rd_data;
      @(negedge clk); #1; b = rd_data;
      check("R6 step", b - a, 64'd1);
      // R7 read-only write rejected
      acc(0, 1, 0, 32, '1, 0, "R7");
      acc(1, 0, 0, 32, 0, 0, "R7");
      acc(0, 1, 0, 33, '1, 0, "R7");
      acc(1, 0, 0, 33, 0, 0, "R7");
      // R9 squash
      acc(0, 1, 1, 2, 64'h77, 0, "R9");
      acc(0, 1, 1, 32, 64'h77, 0, "R9");
      acc(1, 0, 0, 2, 0, 0, "R9");
      // R10 read during write returns old value
      acc(1, 1, 0, 4, 64'habc, 0, "R10");
      acc(1, 0, 0, 4, 0, 0, "R10");
      // random mix
      void'($urandom(32'd1234));
      for (int i = 0; i < 600; i++) begin
         int ix;
         ix = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 36);
         acc(1'($urandom), 1'($urandom), ($urandom % 8) == 0, ix,
             {$urandom, $urandom}, ($urandom % 6 == 0) ? 64'(1) << ($urandom % 64) : 64'h0,
             "R2/R3 random");
      end
      @(negedge clk); rd_en = 0; wr_en = 0; #1;
      check("R8 idle", rd_data, 64'h0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule